// File: doc/BRIEF.md
# Watchdog Timer with Selectable Reset Scope

This block is a register-mapped watchdog. A 32-bit down-counter steps once per pulse of a 1 MHz tick input while counting is enabled. Software keeps the counter from running out by writing a fixed 32-bit key to a restart register, which copies the programmed reload value into the counter. If the counter runs out, the block sets a sticky timeout flag. When reset-on-expiry is enabled, it also raises a reset request for a programmable number of clock cycles.

The scope of the request comes from a two-bit mode field in the control register: SoC, whole chip or CPU only. In SoC mode a 26-bit per-peripheral select vector is presented with the request. When the request ends, the block clears its own enable bit, so software can poll that bit to see that the reset was delivered. The register window spans 0x20 bytes, so several copies can be placed side by side at that stride. The surrounding fabric decodes which copy is selected. The block itself produces only the request and its scope, not the resets.

Top module: `wdog_core`

## Requirements
- R1: After reset the counter status register (0x00) reads 0x0000_1000, control (0x0C) reads 0x0000_0010, timeout status (0x10) reads 0, and `rst_req` is low.
- R2: Reload (0x04) reads back all 32 bits written. Pulse width (0x18) reads back bits 7:0 only. Mask (0x1C) reads back bits 25:0 with bits 31:26 as zero. Control bit 4 always reads 1, and control bit 7 is a plain read/write flag. Writes to 0x00 have no effect.
- R3: A write of exactly 0x0000_4755 to 0x08 loads the reload value into the counter. Any other value written to 0x08 leaves the counter unchanged.
- R4: While control bit 0 is set, each clock edge that sees `tick_1us` high decrements the counter by one. With bit 0 clear, or with no tick, the counter holds its value.
- R5: A tick that finds the counter at 1 (or 0) is an expiry, so a reload value of 1 expires on the first tick.
- R6: An expiry with control bit 1 set and mode 0, 1 or 2 sets timeout status bit 0, reloads the counter, and raises `rst_req` from the next cycle for as many cycles as the width register holds. A width of 0 counts as 1.
- R7: While `rst_req` is high, `rst_mode` carries the mode captured at expiry: 0 = SoC, 1 = whole chip, 2 = CPU.
- R8: `rst_mask` equals mask bits 25:0 while `rst_req` is high in mode 0. In every other case it is zero.
- R9: Control bit 0 reads 0 from the cycle in which `rst_req` falls. Other control bits are kept.
- R10: An expiry with control bit 1 clear, or with mode 3, sets timeout status bit 0 and reloads the counter. No request is raised, and counting continues.
- R11: Writing 0x14 with bit 0 set clears timeout status bit 0. Writing 0 there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 5 | Byte offset inside the 0x20 window; bits 1:0 are ignored |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at `bus_addr`, combinational |
| tick_1us | input | 1 | One-cycle 1 MHz count strobe |
| rst_req | output | 1 | Reset request pulse |
| rst_mode | output | 2 | Reset scope captured at expiry |
| rst_mask | output | 26 | Peripheral select vector, nonzero only for SoC scope |

## Verification
Register writes and restarts take effect at the clock edge that samples the strobe, so a read-back is due in the following low phase. A tick takes one edge to change the counter and the flag. `rst_req` rises at that same expiry edge, stays high for exactly the width count of edges, and drops together with the enable bit. The bench drives every stimulus on a falling edge and queues each expected value at a fixed falling-edge offset derived from these edge counts: one phase after a write or tick, and N edges after expiry for the pulse end. The monitor compares the queued value against the live port in that same low phase.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned MASK_W   = 26;
  localparam int unsigned SEL_W    = 3;
  localparam logic [31:0] KEY      = 32'h0000_4755;

  localparam logic [SEL_W-1:0] OFS_COUNT   = 3'd0;
  localparam logic [SEL_W-1:0] OFS_RELOAD  = 3'd1;
  localparam logic [SEL_W-1:0] OFS_RESTART = 3'd2;
  localparam logic [SEL_W-1:0] OFS_CTRL    = 3'd3;
  localparam logic [SEL_W-1:0] OFS_TSTAT   = 3'd4;
  localparam logic [SEL_W-1:0] OFS_TCLR    = 3'd5;
  localparam logic [SEL_W-1:0] OFS_WIDTH   = 3'd6;
  localparam logic [SEL_W-1:0] OFS_MASK    = 3'd7;

  typedef enum logic [1:0] {
    SCOPE_SOC  = 2'd0,
    SCOPE_CHIP = 2'd1,
    SCOPE_CPU  = 2'd2,
    SCOPE_RSVD = 2'd3
  } scope_e;
endpackage

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
  parameter int unsigned CNT_W   = 32,
  parameter logic [CNT_W-1:0] CNT_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             hold,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;
  logic             cnt_en;

  assign step = run && tick && !hold;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (restart) begin
      cnt_d = reload;
    end else if (step) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d  = reload;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt_en = restart || step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_RST;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !step) |=> $stable(cnt_q));
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == $past(reload)));
endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen
  import wdog_pkg::*;
#(
  parameter int unsigned WID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [WID_W-1:0]  width,
  input  logic [1:0]        mode_in,
  input  logic [MASK_W-1:0] mask_in,
  output logic              req,
  output logic [1:0]        mode_out,
  output logic [MASK_W-1:0] mask_out,
  output logic              done
);
  logic [WID_W-1:0] left_q, left_d;
  logic [1:0]       mode_q;
  logic             busy;

  assign busy = (left_q != '0);
  assign done = (left_q == WID_W'(1));

  always_comb begin
    left_d = left_q;
    if (fire)      left_d = (width == '0) ? WID_W'(1) : width;
    else if (busy) left_d = left_q - WID_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left_q <= '0;
    else if (fire || busy)  left_q <= left_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= SCOPE_SOC;
    else if (fire) mode_q <= mode_in;
  end

  assign req      = busy;
  assign mode_out = mode_q;
  assign mask_out = (busy && mode_q == SCOPE_SOC) ? mask_in : '0;

  assert_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> req);
  assert_idle_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !req);
  assert_scope_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_out != '0) |-> (req && mode_out == SCOPE_SOC));
endmodule

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned WID_W   = 8,
  parameter logic [DATA_W-1:0] RELOAD_RST = 32'h0000_1000,
  parameter logic [WID_W-1:0]  WIDTH_RST  = WID_W'(4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] count,
  input  logic              expire,
  input  logic              pulse_done,
  output logic              run,
  output logic              restart,
  output logic              fire,
  output logic [DATA_W-1:0] reload,
  output logic [WID_W-1:0]  width,
  output logic [1:0]        mode,
  output logic [MASK_W-1:0] mask
);
  logic [SEL_W-1:0] sel;
  logic en_q, en_d, rsten_q, boot_q, tout_q, tout_d;
  logic [1:0] mode_q;
  logic [DATA_W-1:0] reload_q;
  logic [WID_W-1:0]  width_q;
  logic [MASK_W-1:0] mask_q;
  logic wr_ctrl, wr_reload, wr_width, wr_mask, wr_clr;

  assign sel       = addr[SEL_W+1:2];
  assign wr_ctrl   = we && (sel == OFS_CTRL);
  assign wr_reload = we && (sel == OFS_RELOAD);
  assign wr_width  = we && (sel == OFS_WIDTH);
  assign wr_mask   = we && (sel == OFS_MASK);
  assign wr_clr    = we && (sel == OFS_TCLR) && wdata[0];
  assign restart   = we && (sel == OFS_RESTART) && (wdata == KEY);

  always_comb begin
    en_d = en_q;
    if (wr_ctrl)    en_d = wdata[0];
    if (pulse_done) en_d = 1'b0;
    tout_d = tout_q;
    if (wr_clr)     tout_d = 1'b0;
    if (expire)     tout_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; rsten_q <= 1'b0; mode_q <= SCOPE_SOC; boot_q <= 1'b0;
    end else begin
      if (wr_ctrl || pulse_done) en_q <= en_d;
      if (wr_ctrl) begin
        rsten_q <= wdata[1];
        mode_q  <= wdata[6:5];
        boot_q  <= wdata[7];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tout_q <= 1'b0;
    else if (wr_clr || expire)  tout_q <= tout_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RELOAD_RST; width_q <= WIDTH_RST; mask_q <= '0;
    end else begin
      if (wr_reload) reload_q <= wdata;
      if (wr_width)  width_q  <= wdata[WID_W-1:0];
      if (wr_mask)   mask_q   <= wdata[MASK_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      OFS_COUNT:  rdata = count;
      OFS_RELOAD: rdata = reload_q;
      OFS_CTRL:   rdata = {24'd0, boot_q, mode_q, 1'b1, 2'b00, rsten_q, en_q};
      OFS_TSTAT:  rdata = {31'd0, tout_q};
      OFS_WIDTH:  rdata = DATA_W'(width_q);
      OFS_MASK:   rdata = DATA_W'(mask_q);
      default:    rdata = '0;
    endcase
  end

  assign run    = en_q;
  assign fire   = expire && rsten_q && (mode_q != SCOPE_RSVD);
  assign reload = reload_q;
  assign width  = width_q;
  assign mode   = mode_q;
  assign mask   = mask_q;

  assert_en_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_done |=> !en_q);
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> tout_q);
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_q && !wr_clr) |=> tout_q);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned WID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_1us,
  output logic              rst_req,
  output logic [1:0]        rst_mode,
  output logic [25:0]       rst_mask
);
  localparam logic [DATA_W-1:0] RELOAD_RST = 32'h0000_1000;

  logic [DATA_W-1:0] count, reload;
  logic [WID_W-1:0]  width;
  logic [1:0]        mode;
  logic [MASK_W-1:0] mask;
  logic run, restart, fire, expire, pulse_done;

  wdog_regfile #(.ADDR_W(ADDR_W), .WID_W(WID_W), .RELOAD_RST(RELOAD_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .rdata(bus_rdata), .count(count), .expire(expire), .pulse_done(pulse_done),
    .run(run), .restart(restart), .fire(fire), .reload(reload), .width(width),
    .mode(mode), .mask(mask)
  );

  wdog_down_counter #(.CNT_W(DATA_W), .CNT_RST(RELOAD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_1us), .hold(rst_req),
    .restart(restart), .reload(reload), .count(count), .expire(expire)
  );

  wdog_pulse_gen #(.WID_W(WID_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .width(width), .mode_in(mode),
    .mask_in(mask), .req(rst_req), .mode_out(rst_mode), .mask_out(rst_mask),
    .done(pulse_done)
  );
endmodule

// File: tb/test_wdog_core.sv
`timescale 1ns/100ps
module test_wdog_core;
  logic clk = 1'b0;
  logic rst_n;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        tick_1us;
  logic        rst_req;
  logic [1:0]  rst_mode;
  logic [25:0] rst_mask;

  always #2.5 clk = ~clk;

  wdog_core i_wdog_core (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_1us(tick_1us),
    .rst_req(rst_req), .rst_mode(rst_mode), .rst_mask(rst_mask)
  );

  typedef struct {
    int          src;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_checks = 0;
  int    n_errors = 0;
  int    cycles   = 0;

  // monitor: pops the oldest expectation and compares it with the live port
  always @(chk_ev) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.src)
        0: act = bus_rdata;
        1: act = {31'd0, rst_req};
        2: act = {30'd0, rst_mode};
        default: act = {6'd0, rst_mask};
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int src, input logic [31:0] exp, input string tag);
    item_t it;
    it.src = src; it.exp = exp; it.tag = tag;
    q.push_back(it);
    -> chk_ev;
    #0.1;
  endtask

  task automatic expect_reg(input logic [4:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #0.1;
    push(0, exp, tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1us = 1'b1;
      @(negedge clk);
      tick_1us = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; tick_1us = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    expect_reg(5'h00, 32'h0000_1000, "R1 counter");
    expect_reg(5'h0C, 32'h0000_0010, "R1 control");
    expect_reg(5'h10, 32'h0, "R1 tstat");
    push(1, 32'h0, "R1 rst_req");

    // R2 read-back
    wr(5'h04, 32'hDEAD_BEEF);
    expect_reg(5'h04, 32'hDEAD_BEEF, "R2 reload");
    wr(5'h1C, 32'hFFFF_FFFF);
    expect_reg(5'h1C, 32'h03FF_FFFF, "R2 mask");
    wr(5'h18, 32'h0000_01FF);
    expect_reg(5'h18, 32'h0000_00FF, "R2 width");
    wr(5'h00, 32'h0);
    expect_reg(5'h00, 32'h0000_1000, "R2 counter write ignored");

    // R3 key
    wr(5'h04, 32'd5);
    wr(5'h08, 32'h0000_4754);
    expect_reg(5'h00, 32'h0000_1000, "R3 wrong key");
    wr(5'h08, 32'h0001_4755);
    expect_reg(5'h00, 32'h0000_1000, "R3 wrong upper bits");
    wr(5'h08, 32'h0000_4755);
    expect_reg(5'h00, 32'd5, "R3 key restart");

    // R4 counting
    ticks(1);
    expect_reg(5'h00, 32'd5, "R4 disabled holds");
    wr(5'h0C, 32'h1);
    ticks(2);
    expect_reg(5'h00, 32'd3, "R4 two ticks");
    idle(3);
    expect_reg(5'h00, 32'd3, "R4 no tick holds");

    // R10 expiry without reset enable
    ticks(3);
    expect_reg(5'h00, 32'd5, "R10 reloaded");
    expect_reg(5'h10, 32'h1, "R10 flag");
    push(1, 32'h0, "R10 no request");

    // R11 clear
    wr(5'h14, 32'h0);
    expect_reg(5'h10, 32'h1, "R11 write 0 ignored");
    wr(5'h14, 32'h1);
    expect_reg(5'h10, 32'h0, "R11 cleared");

    // R5 / R10 reserved mode, reload of 1
    wr(5'h04, 32'd1);
    wr(5'h08, 32'h0000_4755);
    wr(5'h0C, 32'h63);
    ticks(1);
    expect_reg(5'h10, 32'h1, "R5 one-tick expiry");
    push(1, 32'h0, "R10 mode 3 no request");
    expect_reg(5'h0C, 32'h73, "R10 enable kept");
    expect_reg(5'h00, 32'd1, "R10 reload 1");
    wr(5'h14, 32'h1);

    // R6/R7/R8/R9 SoC mode, width 3
    wr(5'h18, 32'd3);
    wr(5'h1C, 32'h02A5_A5A5);
    wr(5'h0C, 32'h03);
    push(3, 32'h0, "R8 mask idle");
    ticks(1);
    push(1, 32'h1, "R6 request raised");
    push(2, 32'h0, "R7 soc mode");
    push(3, 32'h02A5_A5A5, "R8 soc mask");
    expect_reg(5'h10, 32'h1, "R6 flag");
    idle(2);
    push(1, 32'h1, "R6 request third cycle");
    expect_reg(5'h0C, 32'h13, "R9 enable during pulse");
    idle(1);
    push(1, 32'h0, "R6 request width 3 ended");
    expect_reg(5'h0C, 32'h12, "R9 enable cleared");
    push(3, 32'h0, "R8 mask after pulse");
    wr(5'h14, 32'h1);

    // chip mode, width 0 -> one cycle
    wr(5'h18, 32'd0);
    wr(5'h08, 32'h0000_4755);
    wr(5'h0C, 32'h23);
    ticks(1);
    push(1, 32'h1, "R6 width 0 request");
    push(2, 32'h1, "R7 chip mode");
    push(3, 32'h0, "R8 chip mask zero");
    idle(1);
    push(1, 32'h0, "R6 width 0 one cycle");
    expect_reg(5'h0C, 32'h32, "R9 chip enable cleared");

    // CPU mode with second-boot flag, width 2
    wr(5'h18, 32'd2);
    wr(5'h08, 32'h0000_4755);
    wr(5'h0C, 32'hC3);
    expect_reg(5'h0C, 32'hD3, "R2 flag bit 7");
    ticks(1);
    push(2, 32'h2, "R7 cpu mode");
    push(3, 32'h0, "R8 cpu mask zero");
    idle(1);
    push(1, 32'h1, "R6 width 2 second cycle");
    idle(1);
    push(1, 32'h0, "R6 width 2 ended");
    expect_reg(5'h0C, 32'hD2, "R9 cpu enable cleared, flags kept");

    idle(2);
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule